// File: doc/BRIEF.md
# Branch and Return-Stack Program Sequencer

This block keeps the program counter of a small signal-processing core that runs 24-bit instruction words. On every cycle where the fetch logic strobes `adv`, the block looks at the word fetched from the current PC and picks the next PC. The choices are:

- the sequential address;
- an absolute jump inside a selected bank;
- a subroutine call;
- a return taken from a small circular stack;
- a branch that depends on the accumulator flag sets, the low nibble of the data pointer or the handshake/serial status bits;
- an indirect jump through the serial-output register.

Instruction memory and the arithmetic unit are outside the block. They supply the word, the flags and the status bits, and they take `pc` as the fetch address. The PC is a registered output and is 14 bits wide. The return stack is a parameterised circular buffer of 4 or 8 entries. Pushing past its depth overwrites the oldest entry and never raises an error.

Top module: `prog_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` and the stack pointer become 0. The first cycle after reset shows `pc` = 0.
- R2: At an edge where `adv` is low, `pc` and the stack keep their values, whatever `instr` holds.
- R3: With `adv` high, the sequential instruction classes load `pc` with (pc+1) mod 2^14. The class is `instr[23:22]`: 00 is operate and 11 is load-immediate. The same applies to a jump word (class 10) whose 9-bit code `instr[21:13]` is not listed in R4–R9, including the odd codes between 0x80 and 0xAF and the codes 0xB5, 0xB7, 0xB9, 0xBB, 0xBD and 0xBF.
- R4: Code 0x100 loads `pc` with {0, instr[1:0], instr[12:2]}. Code 0x101 loads `pc` with {1, instr[1:0], instr[12:2]}.
- R5: Each even code from 0x80 to 0xAE tests one flag. In the flag vectors, bit 0 is carry, bit 1 zero, bit 2 overflow-0, bit 3 overflow-1, bit 4 sign-0 and bit 5 sign-1. Within the code, bits [5:3] give the flag index, bit 2 chooses set B over set A, and bit 1 is the value that makes the branch taken. A taken branch loads `pc` with {bit 13 of pc+1, instr[1:0], instr[12:2]}. A branch that is not taken loads pc+1.
- R6: Codes 0xB0, 0xB1, 0xB2 and 0xB3 are taken when `dp_low` is, in that order, 0, not 0, 0xF, or not 0xF. A taken branch uses the R5 target.
- R7: Codes 0xB4/0xB6 test `sin_ctl`, 0xB8/0xBA test `sout_ctl` and 0xBC/0xBE test `req_master`. The lower code of each pair is taken when the bit is 0 and the upper code when it is 1. A taken branch uses the R5 target.
- R8: Code 0x000 loads `pc` from `sout_val`.
- R9: Codes 0x140 and 0x141 jump as 0x100 and 0x101 do. Before the jump they write pc+1 into the stack entry at the stack pointer and then advance the pointer modulo DEPTH. A word of class 01 steps the pointer back modulo DEPTH and loads `pc` from that entry.
- R10: The stack is circular. After DEPTH+1 calls with no return in between, the first entry has been overwritten. Returns then replay the entries in pointer order around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | The fetched word is valid; advance the sequencer |
| instr | input | 24 | Instruction word fetched from `pc` |
| flags_a | input | 6 | Flag set A: {s1, s0, ov1, ov0, zero, carry} |
| flags_b | input | 6 | Flag set B, same layout |
| dp_low | input | 4 | Low nibble of the data pointer |
| sin_ctl | input | 1 | Serial-in control status bit |
| sout_ctl | input | 1 | Serial-out control status bit |
| req_master | input | 1 | Request-for-master status bit |
| sout_val | input | 14 | Serial-output register value, used as an indirect target |
| pc | output | 14 | Program counter (registered) |

## Verification
The bound checker tests the following on every cycle:

- the reset value;
- that the PC holds when `adv` is low;
- the wrap-around increment for sequential classes;
- both forms of the unconditional jump;
- the serial-out indirect jump;
- the modulo movement of the stack pointer on calls and returns.

The returned address itself, the taken or not-taken decision for every flag, nibble and status code, and the overwrite of entries when the ring wraps can only be shown by the bench's scenarios. The bench compares each of those against its behavioural model.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  localparam int ADDR_W = 11;
  localparam int BANK_W = 2;
  localparam int PC_W   = 1 + BANK_W + ADDR_W;
  localparam int JT_W   = 9;
  localparam int IW_W   = 24;
  localparam int FLG_W  = 6;

  typedef enum logic [1:0] {
    CLS_OP    = 2'b00,
    CLS_OPRET = 2'b01,
    CLS_JUMP  = 2'b10,
    CLS_LDI   = 2'b11
  } iclass_e;

  localparam logic [JT_W-1:0] JC_SERIAL = 9'h000;
  localparam logic [JT_W-1:0] JC_JMP_LO = 9'h100;
  localparam logic [JT_W-1:0] JC_JMP_HI = 9'h101;
  localparam logic [JT_W-1:0] JC_CAL_LO = 9'h140;
  localparam logic [JT_W-1:0] JC_CAL_HI = 9'h141;
endpackage

// File: rtl/prog_seq_cond.sv
module prog_seq_cond
  import prog_seq_pkg::*;
(
  input  logic [JT_W-1:0]  code,
  input  logic [FLG_W-1:0] fa,
  input  logic [FLG_W-1:0] fb,
  input  logic [3:0]       nib,
  input  logic             s_in,
  input  logic             s_out,
  input  logic             s_req,
  output logic             taken
);
  logic is_flag, is_nib, is_stat;
  logic [2:0] fidx;
  logic [FLG_W-1:0] fsel;
  logic fbit, sbit, nib_hit;

  assign is_flag = (code[8:6] == 3'b010) && (code[5:4] != 2'b11) && !code[0];
  assign is_nib  = (code[8:2] == 7'b0101100);
  assign is_stat = (code[8:4] == 5'b01011) && (code[3:2] != 2'b00) && !code[0];

  assign fidx = code[5:3];
  assign fsel = code[2] ? fb : fa;
  assign fbit = (fidx < 3'(FLG_W)) ? fsel[fidx] : 1'b0;

  always_comb begin
    case (code[3:2])
      2'b01:   sbit = s_in;
      2'b10:   sbit = s_out;
      default: sbit = s_req;
    endcase
  end

  always_comb begin
    case (code[1:0])
      2'b00:   nib_hit = (nib == 4'h0);
      2'b01:   nib_hit = (nib != 4'h0);
      2'b10:   nib_hit = (nib == 4'hF);
      default: nib_hit = (nib != 4'hF);
    endcase
  end

  always_comb begin
    taken = 1'b0;
    if (is_flag)      taken = (fbit == code[1]);
    else if (is_nib)  taken = nib_hit;
    else if (is_stat) taken = (sbit == code[1]);
  end
endmodule

// File: rtl/prog_seq_stack.sv
module prog_seq_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 14,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    rdata,
  output logic [SP_W-1:0] sp
);
  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp_dec;

  assign sp_dec = sp - 1'b1;
  assign rdata  = mem[sp_dec];

  always_ff @(posedge clk) begin
    if (push) mem[sp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp + 1'b1;
    else if (pop)  sp <= sp_dec;
  end
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [IW_W-1:0]  instr,
  input  logic [FLG_W-1:0] flags_a,
  input  logic [FLG_W-1:0] flags_b,
  input  logic [3:0]       dp_low,
  input  logic             sin_ctl,
  input  logic             sout_ctl,
  input  logic             req_master,
  input  logic [PC_W-1:0]  sout_val,
  output logic [PC_W-1:0]  pc
);
  localparam int SP_W = $clog2(DEPTH);

  iclass_e         cls;
  logic [JT_W-1:0] jcode;
  logic [PC_W-1:0] pc_inc, tgt, pc_nx, stk_top;
  logic [SP_W-1:0] sp_w;
  logic            cond_hit, do_call, do_ret;

  assign cls    = iclass_e'(instr[23:22]);
  assign jcode  = instr[21:13];
  assign pc_inc = pc + 1'b1;
  assign tgt    = {pc_inc[PC_W-1], instr[BANK_W-1:0], instr[ADDR_W+BANK_W-1:BANK_W]};

  assign do_call = adv && (cls == CLS_JUMP) && ((jcode == JC_CAL_LO) || (jcode == JC_CAL_HI));
  assign do_ret  = adv && (cls == CLS_OPRET);

  prog_seq_cond u_cond (
    .code  (jcode),
    .fa    (flags_a),
    .fb    (flags_b),
    .nib   (dp_low),
    .s_in  (sin_ctl),
    .s_out (sout_ctl),
    .s_req (req_master),
    .taken (cond_hit)
  );

  prog_seq_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (do_call),
    .pop   (do_ret),
    .wdata (pc_inc),
    .rdata (stk_top),
    .sp    (sp_w)
  );

  always_comb begin
    pc_nx = pc_inc;
    case (cls)
      CLS_OPRET: pc_nx = stk_top;
      CLS_JUMP: begin
        if (jcode == JC_SERIAL)
          pc_nx = sout_val;
        else if ((jcode == JC_JMP_LO) || (jcode == JC_CAL_LO))
          pc_nx = {1'b0, tgt[PC_W-2:0]};
        else if ((jcode == JC_JMP_HI) || (jcode == JC_CAL_HI))
          pc_nx = {1'b1, tgt[PC_W-2:0]};
        else if (cond_hit)
          pc_nx = tgt;
      end
      default: pc_nx = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      pc <= '0;
    else if (adv) pc <= pc_nx;
  end
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk
  import prog_seq_pkg::*;
#(
  parameter int SP_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            adv,
  input logic [IW_W-1:0] instr,
  input logic [PC_W-1:0] sout_val,
  input logic [PC_W-1:0] pc,
  input logic [SP_W-1:0] sp
);
  // R1
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0 && sp == '0));

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv) |=> ($stable(pc) && $stable(sp)));

  // R3
  a_r3_seq_inc: assert property (@(posedge clk) disable iff (rst)
    (adv && (instr[23:22] == 2'b00 || instr[23:22] == 2'b11))
      |=> pc == PC_W'($past(pc) + 1));

  // R4
  a_r4_jump_hi: assert property (@(posedge clk) disable iff (rst)
    (adv && instr[23:22] == 2'b10 && instr[21:13] == 9'h101)
      |=> pc == {1'b1, $past(instr[1:0]), $past(instr[12:2])});

  // R4
  a_r4_jump_lo: assert property (@(posedge clk) disable iff (rst)
    (adv && instr[23:22] == 2'b10 && instr[21:13] == 9'h100)
      |=> pc == {1'b0, $past(instr[1:0]), $past(instr[12:2])});

  // R8
  a_r8_serial: assert property (@(posedge clk) disable iff (rst)
    (adv && instr[23:22] == 2'b10 && instr[21:13] == 9'h000)
      |=> pc == $past(sout_val));

  // R9
  a_r9_call_sp: assert property (@(posedge clk) disable iff (rst)
    (adv && instr[23:22] == 2'b10 && (instr[21:13] == 9'h140 || instr[21:13] == 9'h141))
      |=> sp == SP_W'($past(sp) + 1));

  // R9
  a_r9_ret_sp: assert property (@(posedge clk) disable iff (rst)
    (adv && instr[23:22] == 2'b01) |=> sp == SP_W'($past(sp) - 1));
endmodule

bind prog_seq prog_seq_chk #(.SP_W(SP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .adv      (adv),
  .instr    (instr),
  .sout_val (sout_val),
  .pc       (pc),
  .sp       (sp_w)
);

// File: tb/prog_seq_tb.sv
module prog_seq_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv = 1'b0;
  logic [23:0] instr = '0;
  logic [5:0]  fa = '0, fb = '0;
  logic [3:0]  dp = '0;
  logic        sic = 1'b0, soc = 1'b0, rqm = 1'b0;
  logic [13:0] sov = '0;
  logic [13:0] pc;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  int m_pc = 0, m_sp = 0;
  int m_stk [DEPTH];

  always #4 clk = ~clk;

  prog_seq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .adv(adv), .instr(instr),
    .flags_a(fa), .flags_b(fb), .dp_low(dp),
    .sin_ctl(sic), .sout_ctl(soc), .req_master(rqm),
    .sout_val(sov), .pc(pc)
  );

  function automatic logic [23:0] jw(input int code, input int bank, input int addr);
    jw = {2'b10, 9'(code), 11'(addr), 2'(bank)};
  endfunction

  task automatic check(input int exp);
    n_chk++;
    if (int'(pc) != exp) begin
      n_fail++;
      $display("FAIL %s: pc=%h expected %h", tag, pc, exp[13:0]);
    end
  endtask

  // Behavioural reference: next PC from the current model state
  task automatic model(input logic [23:0] w);
    int nx, tg, code, k;
    bit tk, v;
    nx = (m_pc + 1) % 16384;
    code = int'(w[21:13]);
    tg = (nx / 8192) * 8192 + int'(w[1:0]) * 2048 + int'(w[12:2]);
    case (w[23:22])
      2'b00, 2'b11: m_pc = nx;
      2'b01: begin
        m_sp = (m_sp + DEPTH - 1) % DEPTH;
        m_pc = m_stk[m_sp];
      end
      default: begin
        tk = 0;
        if (code == 0) begin m_pc = int'(sov); end
        else if (code == 256 || code == 257 || code == 320 || code == 321) begin
          if (code >= 320) begin
            m_stk[m_sp] = nx;
            m_sp = (m_sp + 1) % DEPTH;
          end
          m_pc = (tg % 8192) + ((code % 2) * 8192);
        end else begin
          if (code >= 128 && code <= 174 && code % 2 == 0) begin
            k = (code - 128) / 2;
            v = ((k / 2) % 2) ? fb[k / 4] : fa[k / 4];
            tk = (v == bit'(k % 2));
          end else if (code == 176) tk = (dp == 0);
          else if (code == 177) tk = (dp != 0);
          else if (code == 178) tk = (dp == 15);
          else if (code == 179) tk = (dp != 15);
          else if (code >= 180 && code <= 190 && code % 2 == 0) begin
            k = (code - 180) / 4;
            v = (k == 0) ? sic : (k == 1) ? soc : rqm;
            tk = (v == bit'(((code - 180) / 2) % 2));
          end
          m_pc = tk ? tg : nx;
        end
      end
    endcase
  endtask

  task automatic step(input logic [23:0] w);
    instr = w;
    adv = 1'b1;
    model(w);
    @(posedge clk);
    @(negedge clk);
    check(m_pc);
  endtask

  task automatic idle(input logic [23:0] w);
    instr = w;
    adv = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(m_pc);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: pc=%h expected completion", pc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1"; check(0);

    tag = "R2";
    idle(jw(256, 3, 100));
    idle({2'b01, 22'h0});
    idle(24'hFFFFFF);

    tag = "R3";
    step(24'h000000);
    step(24'hC12345);
    step(jw(129, 1, 5));
    step(jw(181, 2, 9));
    step(jw(191, 2, 9));
    step(jw(80, 0, 1));
    step(jw(511, 3, 7));
    step(jw(257, 3, 2047));
    step(24'h3ABCDE);

    tag = "R4";
    step(jw(256, 2, 1234));
    step(jw(257, 1, 77));
    step(jw(256, 3, 2047));

    tag = "R5";
    for (int c = 128; c <= 174; c += 2) begin
      fa = 6'h00; fb = 6'h00; step(jw(c, 1, c));
      fa = 6'h3F; fb = 6'h3F; step(jw(c, 2, c + 3));
      fa = 6'h15; fb = 6'h2A; step(jw(c, 3, c + 7));
      fa = 6'h2A; fb = 6'h15; step(jw(c, 0, c + 11));
    end

    tag = "R6";
    for (int d = 0; d < 16; d += 5) begin
      dp = 4'(d);
      for (int c = 176; c <= 179; c++) step(jw(c, 1, 300 + c));
    end

    tag = "R7";
    for (int p = 0; p < 8; p++) begin
      sic = p[0]; soc = p[1]; rqm = p[2];
      for (int c = 180; c <= 190; c += 2) step(jw(c, 2, 500 + c + p));
    end

    tag = "R8";
    sov = 14'h2A5C; step(jw(0, 3, 3));
    sov = 14'h0011; step(jw(0, 1, 1));

    tag = "R9";
    step(jw(320, 1, 40));
    step(24'h000000);
    step(jw(321, 2, 60));
    step(24'hC00001);
    step({2'b01, 22'h12345});
    step({2'b01, 22'h0});

    tag = "R10";
    for (int i = 0; i < DEPTH + 1; i++) begin
      step(24'h000000);
      step(jw(320 + (i % 2), i % 4, 100 * i + 9));
    end
    for (int i = 0; i < DEPTH + 1; i++) step({2'b01, 22'h0});
    step(24'h000000);

    tag = "R2";
    idle(jw(321, 1, 1));
    idle({2'b01, 22'h0});
    step({2'b01, 22'h0});

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule